// File: doc/BRIEF.md
# Ethernet Transmit Start and Underrun Controller

This block decides when a MAC transmitter may begin sending a frame from its transmit FIFO. Software arms a transmission by writing a two-bit command field. The command selects one of two transmit modes. In local-DMA mode a DMA engine keeps refilling the FIFO from packet memory while the frame goes out. In direct-FIFO mode the host fills the FIFO itself. Transmission starts only when three things hold: the interframe gap timer has expired, the FIFO holds a whole packet or is full, and any collision backoff has ended.

During a local-DMA frame the block raises a refill request toward the packet-memory arbiter. The request appears once FIFO free space reaches a programmable fraction of the FIFO depth. A small fraction refills early and keeps the FIFO fuller. A large fraction leaves more memory bandwidth for the host and receive traffic. If the serializer asks for a byte while the FIFO is empty, the frame is aborted. A sticky error flag is then set and can raise an interrupt. When a frame finishes normally, the command field returns to zero and a 4-bit completion status is written.

Top module: `tx_start_ctrl`

## Requirements
- R1: After reset, `cmd_q` is 2'b00, `dma_status` is 4'h0, `int_status` and `int_mask` are zero, and `tx_start`, `tx_abort`, `fetch_req` and `irq` are 0.
- R2: Only command values 2'b01 (local-DMA mode) and 2'b10 (direct-FIFO mode) can start a frame. Values 2'b00 and 2'b11 are stored but never produce `tx_start`.
- R3: In idle, `tx_start` pulses for exactly one cycle. The pulse comes one cycle after a clock edge that sees all of the following: a startable command, `ifg_done` high, `fifo_eop` high or `fifo_level` equal to the FIFO depth, and no backoff pending.
- R4: A `collision` during a frame returns the block to idle and keeps the command. No new start is made until a `backoff_done` pulse has been seen.
- R5: In local-DMA mode while a frame is in progress, `fetch_req` is 1 exactly when free space (depth minus `fifo_level`) is at least (`thr_sel`+1)/4 of the depth. So `thr_sel` 0,1,2,3 mean 1/4, 1/2, 3/4 and all of the depth.
- R6: In direct-FIFO mode `fetch_req` stays 0 whatever `thr_sel` and `fifo_level` are. It is also 0 while no frame is in progress.
- R7: An underrun is `ser_rd` high with `fifo_level` zero during a frame, when neither `ser_done` nor `collision` is present. On underrun, `tx_abort` pulses for one cycle, `cmd_q` clears to 2'b00, and `dma_status` is left unchanged.
- R8: An underrun sets bit 5 of `int_status`. Writing 1 to that bit clears it, and writing 0 leaves it set. `irq` is 1 exactly when a set status bit has its `int_mask` bit at 1.
- R9: When `ser_done` ends a frame, `cmd_q` clears to 2'b00 and `dma_status` becomes 4'h1.
- R10: Command writes made while a frame is in progress or being aborted are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command field |
| cmd_wdata | input | 2 | Command value (01 local DMA, 10 direct FIFO) |
| thr_sel | input | 2 | Refill threshold select |
| istat_wr | input | 1 | Write strobe for the interrupt status (write 1 to clear) |
| istat_wdata | input | REG_W | Interrupt status clear mask |
| imask_wr | input | 1 | Write strobe for the interrupt mask |
| imask_wdata | input | REG_W | Interrupt mask value |
| fifo_level | input | LVL_W | Bytes held in the transmit FIFO |
| fifo_eop | input | 1 | FIFO holds a complete packet |
| ifg_done | input | 1 | Interframe gap timer expired (level) |
| backoff_done | input | 1 | Backoff timer expired (pulse) |
| collision | input | 1 | Collision detected during the frame (pulse) |
| ser_rd | input | 1 | Serializer requests a byte |
| ser_done | input | 1 | Serializer finished the frame (pulse) |
| tx_start | output | 1 | One-cycle start pulse to the serializer |
| fetch_req | output | 1 | Packet-memory refill request |
| tx_abort | output | 1 | One-cycle abort pulse on underrun |
| irq | output | 1 | Interrupt request |
| cmd_q | output | 2 | Current command field |
| dma_status | output | 4 | Transmit completion status |
| int_status | output | REG_W | Interrupt status register |
| int_mask | output | REG_W | Interrupt mask register |

## Verification
The assertions assume that `collision`, `ser_rd` and `ser_done` are driven only while a frame is in progress. They also assume that `ser_done` and `collision` are single-cycle pulses, and that `fifo_level` never exceeds the FIFO depth. The stimulus follows these rules. It raises serializer and collision events only in cycles after `tx_start`, drops each event after one clock, and keeps every level between zero and the depth.

// File: rtl/txs_pkg.sv
package txs_pkg;

    typedef enum logic [1:0] {
        TXS_IDLE  = 2'd0,
        TXS_SEND  = 2'd1,
        TXS_ABORT = 2'd2
    } txs_state_e;

    localparam logic [1:0] CMD_NONE  = 2'b00;
    localparam logic [1:0] CMD_LDMA  = 2'b01;
    localparam logic [1:0] CMD_DFIFO = 2'b10;

    localparam int          ERR_BIT       = 5;
    localparam logic [3:0]  DMA_DONE_CODE = 4'h1;
    localparam int          THR_STEPS     = 4;

    typedef struct packed {
        logic start;
        logic done;
        logic underrun;
        logic collide;
    } txs_evt_t;

    function automatic logic cmd_can_start(input logic [1:0] c);
        return (c == CMD_LDMA) || (c == CMD_DFIFO);
    endfunction

endpackage

// File: rtl/txs_cmd_reg.sv
module txs_cmd_reg
    import txs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    input  logic       busy,
    input  logic       clr_cmd,
    input  logic       set_done,
    output logic [1:0] cmd_q,
    output logic [3:0] status_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_NONE;
            status_q <= '0;
        end else begin
            if (clr_cmd) begin
                cmd_q <= CMD_NONE;
            end else if (wr_en && !busy) begin
                cmd_q <= wr_data;
            end
            if (set_done) begin
                status_q <= DMA_DONE_CODE;
            end
        end
    end

endmodule

// File: rtl/txs_refill.sv
module txs_refill
    import txs_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int LVL_W = 12
) (
    input  logic             active,
    input  logic             dma_mode,
    input  logic [1:0]       thr_sel,
    input  logic [LVL_W-1:0] level,
    output logic             fetch_req
);

    logic [LVL_W-1:0] thr_tab [THR_STEPS];
    logic [LVL_W-1:0] free_space;

    for (genvar g = 0; g < THR_STEPS; g++) begin : g_thr
        assign thr_tab[g] = LVL_W'(((g + 1) * DEPTH) / THR_STEPS);
    end

    assign free_space = LVL_W'(DEPTH) - level;
    assign fetch_req  = active && dma_mode && (free_space >= thr_tab[thr_sel]);

endmodule

// File: rtl/txs_irq.sv
module txs_irq
    import txs_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_set,
    input  logic             clr_wr,
    input  logic [REG_W-1:0] clr_data,
    input  logic             mask_wr,
    input  logic [REG_W-1:0] mask_data,
    output logic [REG_W-1:0] status_q,
    output logic [REG_W-1:0] mask_q,
    output logic             irq
);

    logic [REG_W-1:0] set_vec;

    always_comb begin
        set_vec          = '0;
        set_vec[ERR_BIT] = err_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (status_q & ~(clr_wr ? clr_data : '0)) | set_vec;
            if (mask_wr) begin
                mask_q <= mask_data;
            end
        end
    end

    assign irq = |(status_q & mask_q);

endmodule

// File: rtl/tx_start_ctrl.sv
module tx_start_ctrl
    import txs_pkg::*;
#(
    parameter  int FIFO_DEPTH = 2048,
    parameter  int REG_W      = 8,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd_wdata,
    input  logic [1:0]       thr_sel,
    input  logic             istat_wr,
    input  logic [REG_W-1:0] istat_wdata,
    input  logic             imask_wr,
    input  logic [REG_W-1:0] imask_wdata,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             fifo_eop,
    input  logic             ifg_done,
    input  logic             backoff_done,
    input  logic             collision,
    input  logic             ser_rd,
    input  logic             ser_done,
    output logic             tx_start,
    output logic             fetch_req,
    output logic             tx_abort,
    output logic             irq,
    output logic [1:0]       cmd_q,
    output logic [3:0]       dma_status,
    output logic [REG_W-1:0] int_status,
    output logic [REG_W-1:0] int_mask
);

    txs_state_e state_q, state_d;
    txs_evt_t   evt;
    logic       bo_pend_q;
    logic       start_q;
    logic       fifo_ready;

    assign fifo_ready = fifo_eop || (fifo_level == LVL_W'(FIFO_DEPTH));

    always_comb begin
        evt          = '0;
        state_d      = state_q;
        unique case (state_q)
            TXS_IDLE: begin
                evt.start = cmd_can_start(cmd_q) && ifg_done && fifo_ready && !bo_pend_q;
                if (evt.start) state_d = TXS_SEND;
            end
            TXS_SEND: begin
                evt.collide  = collision;
                evt.done     = !collision && ser_done;
                evt.underrun = !collision && !ser_done && ser_rd && (fifo_level == '0);
                if (evt.collide || evt.done) state_d = TXS_IDLE;
                else if (evt.underrun)       state_d = TXS_ABORT;
            end
            TXS_ABORT: state_d = TXS_IDLE;
            default:   state_d = TXS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= TXS_IDLE;
            bo_pend_q <= 1'b0;
            start_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= evt.start;
            if (evt.collide)       bo_pend_q <= 1'b1;
            else if (backoff_done) bo_pend_q <= 1'b0;
        end
    end

    assign tx_start = start_q;
    assign tx_abort = (state_q == TXS_ABORT);

    txs_cmd_reg u_cmd (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cmd_wr),
        .wr_data  (cmd_wdata),
        .busy     (state_q != TXS_IDLE),
        .clr_cmd  (evt.done || evt.underrun),
        .set_done (evt.done),
        .cmd_q    (cmd_q),
        .status_q (dma_status)
    );

    txs_refill #(
        .DEPTH (FIFO_DEPTH),
        .LVL_W (LVL_W)
    ) u_refill (
        .active    (state_q == TXS_SEND),
        .dma_mode  (cmd_q == CMD_LDMA),
        .thr_sel   (thr_sel),
        .level     (fifo_level),
        .fetch_req (fetch_req)
    );

    txs_irq #(
        .REG_W (REG_W)
    ) u_irq (
        .clk       (clk),
        .rst       (rst),
        .err_set   (evt.underrun),
        .clr_wr    (istat_wr),
        .clr_data  (istat_wdata),
        .mask_wr   (imask_wr),
        .mask_data (imask_wdata),
        .status_q  (int_status),
        .mask_q    (int_mask),
        .irq       (irq)
    );

endmodule

// File: rtl/txs_chk.sv
module txs_chk #(
    parameter  int FIFO_DEPTH = 2048,
    parameter  int REG_W      = 8,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ifg_done,
    input logic             fifo_eop,
    input logic [LVL_W-1:0] fifo_level,
    input logic             tx_start,
    input logic             fetch_req,
    input logic             tx_abort,
    input logic [1:0]       cmd_q,
    input logic [3:0]       dma_status,
    input logic [REG_W-1:0] int_status
);

    // R3
    start_cond_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> ($past(ifg_done) && ($past(fifo_eop) || $past(fifo_level) == LVL_W'(FIFO_DEPTH))));

    // R2
    start_mode_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> ($past(cmd_q) == 2'b01 || $past(cmd_q) == 2'b10));

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    // R6
    direct_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == 2'b10) |-> !fetch_req);

    // R7
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_abort |=> !tx_abort);

    // R7
    abort_clears_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        tx_abort |-> (cmd_q == 2'b00));

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_status[5]) |-> tx_abort);

    // R9
    status_code_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dma_status) |-> (dma_status == 4'h1));

endmodule

bind tx_start_ctrl txs_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .REG_W      (REG_W)
) u_chk (.*);

// File: tb/tx_start_ctrl_tb.sv
module tx_start_ctrl_tb;

    localparam int DEPTH = 2048;
    localparam int RW    = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_wr = 1'b0;
    logic [1:0]    cmd_wdata = '0;
    logic [1:0]    thr_sel = '0;
    logic          istat_wr = 1'b0;
    logic [RW-1:0] istat_wdata = '0;
    logic          imask_wr = 1'b0;
    logic [RW-1:0] imask_wdata = '0;
    logic [LW-1:0] fifo_level = '0;
    logic          fifo_eop = 1'b0;
    logic          ifg_done = 1'b0;
    logic          backoff_done = 1'b0;
    logic          collision = 1'b0;
    logic          ser_rd = 1'b0;
    logic          ser_done = 1'b0;
    logic          tx_start, fetch_req, tx_abort, irq;
    logic [1:0]    cmd_q;
    logic [3:0]    dma_status;
    logic [RW-1:0] int_status, int_mask;

    tx_start_ctrl #(.FIFO_DEPTH(DEPTH), .REG_W(RW)) u_dut (.*);

    always #4 clk = ~clk;

    typedef struct {
        int          due;
        int          sig;
        int unsigned exp;
        string       req;
    } exp_item_t;

    exp_item_t q[$];
    int cyc = 0;
    int checks = 0;
    int failures = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int unsigned sample(int sig);
        case (sig)
            0: return tx_start;
            1: return fetch_req;
            2: return tx_abort;
            3: return irq;
            4: return cmd_q;
            5: return dma_status;
            default: return int_status;
        endcase
    endfunction

    task automatic expect_at(int dly, int sig, int unsigned exp, string req);
        q.push_back('{cyc + dly, sig, exp, req});
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // monitor: compares scheduled expectations just before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    int unsigned got;
                    got = sample(q[i].sig);
                    checks++;
                    if (got !== q[i].exp) begin
                        failures++;
                        $display("FAIL %s sig=%0d cyc=%0d actual=%0h expected=%0h",
                                 q[i].req, q[i].sig, cyc, got, q[i].exp);
                    end
                    q.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic write_cmd(logic [1:0] v);
        step(); cmd_wr = 1'b1; cmd_wdata = v;
        step(); cmd_wr = 1'b0;
    endtask

    initial begin
        repeat (4) step();
        rst = 1'b0;
        step();
        // R1 reset state
        expect_at(0, 4, 0, "R1"); expect_at(0, 5, 0, "R1");
        expect_at(0, 6, 0, "R1"); expect_at(0, 3, 0, "R1");
        expect_at(0, 0, 0, "R1"); expect_at(0, 2, 0, "R1"); expect_at(0, 1, 0, "R1");

        // R2: non-start command values
        ifg_done = 1'b1; fifo_eop = 1'b1; fifo_level = 100;
        write_cmd(2'b00);
        expect_at(0, 0, 0, "R2"); expect_at(1, 0, 0, "R2"); expect_at(2, 0, 0, "R2");
        write_cmd(2'b11);
        expect_at(0, 4, 3, "R2"); expect_at(1, 0, 0, "R2"); expect_at(2, 0, 0, "R2");
        step(); step();

        // R3: gating by FIFO content and gap timer
        ifg_done = 1'b0; fifo_eop = 1'b0; fifo_level = 100;
        write_cmd(2'b01);
        expect_at(0, 4, 1, "R3"); expect_at(1, 0, 0, "R3");
        step(); fifo_level = DEPTH;
        expect_at(1, 0, 0, "R3"); expect_at(2, 0, 0, "R3");
        step(); step(); ifg_done = 1'b1;
        expect_at(1, 0, 1, "R3"); expect_at(2, 0, 0, "R3");
        step(); step();
        // R5: refill thresholds in local-DMA mode
        thr_sel = 2'd0; fifo_level = DEPTH;     expect_at(0, 1, 0, "R5");
        step(); fifo_level = DEPTH - DEPTH/4;   expect_at(0, 1, 1, "R5");
        step(); fifo_level = DEPTH - DEPTH/4 + 1; expect_at(0, 1, 0, "R5");
        step(); thr_sel = 2'd1; fifo_level = DEPTH/2; expect_at(0, 1, 1, "R5");
        step(); fifo_level = DEPTH/2 + 1;       expect_at(0, 1, 0, "R5");
        step(); thr_sel = 2'd3; fifo_level = 1; expect_at(0, 1, 0, "R5");
        step(); fifo_level = 0;                 expect_at(0, 1, 1, "R5");
        // R10: write during a frame is ignored
        step(); cmd_wr = 1'b1; cmd_wdata = 2'b10;
        step(); cmd_wr = 1'b0; expect_at(0, 4, 1, "R10");
        // R9: normal completion
        step(); ser_done = 1'b1;
        expect_at(1, 4, 0, "R9"); expect_at(1, 5, 1, "R9"); expect_at(1, 1, 0, "R6");
        step(); ser_done = 1'b0;
        expect_at(1, 0, 0, "R9"); expect_at(2, 0, 0, "R9");
        step(); step();

        // R6: direct-FIFO mode never requests refill
        fifo_eop = 1'b1; fifo_level = 1000;
        write_cmd(2'b10);
        expect_at(1, 0, 1, "R2");
        step(); step(); fifo_level = 0; thr_sel = 2'd0;
        expect_at(0, 1, 0, "R6");
        step(); ser_done = 1'b1;
        expect_at(1, 5, 1, "R9"); expect_at(1, 4, 0, "R9");
        step(); ser_done = 1'b0;
        step();

        // R4: collision then backoff
        fifo_level = 1000;
        write_cmd(2'b01);
        expect_at(1, 0, 1, "R4");
        step(); step(); collision = 1'b1;
        expect_at(1, 4, 1, "R4"); expect_at(2, 0, 0, "R4"); expect_at(3, 0, 0, "R4");
        step(); collision = 1'b0;
        step(); step(); step(); expect_at(0, 0, 0, "R4");
        backoff_done = 1'b1;
        expect_at(1, 0, 0, "R4"); expect_at(2, 0, 1, "R4");
        step(); backoff_done = 1'b0;
        step(); step(); ser_done = 1'b1;
        step(); ser_done = 1'b0;
        step();

        // R7/R8: underrun with mask enabled
        step(); imask_wr = 1'b1; imask_wdata = 8'h20;
        step(); imask_wr = 1'b0;
        fifo_level = 1000;
        write_cmd(2'b01);
        step(); fifo_level = 0; ser_rd = 1'b1;
        expect_at(1, 2, 1, "R7"); expect_at(1, 4, 0, "R7"); expect_at(1, 5, 1, "R7");
        expect_at(1, 6, 32'h20, "R8"); expect_at(1, 3, 1, "R8");
        step(); ser_rd = 1'b0; cmd_wr = 1'b1; cmd_wdata = 2'b01;
        expect_at(1, 2, 0, "R7"); expect_at(1, 4, 0, "R10");
        step(); cmd_wr = 1'b0;
        step(); istat_wr = 1'b1; istat_wdata = 8'h20;
        expect_at(1, 6, 0, "R8"); expect_at(1, 3, 0, "R8");
        step(); istat_wr = 1'b0;

        // R8: underrun with mask disabled, write-0 keeps flag
        imask_wr = 1'b1; imask_wdata = 8'h00;
        step(); imask_wr = 1'b0; fifo_level = 1000;
        write_cmd(2'b01);
        step(); fifo_level = 0; ser_rd = 1'b1;
        expect_at(1, 6, 32'h20, "R8"); expect_at(1, 3, 0, "R8");
        step(); ser_rd = 1'b0;
        step(); istat_wr = 1'b1; istat_wdata = 8'h00;
        expect_at(1, 6, 32'h20, "R8");
        step(); istat_wr = 1'b0; imask_wr = 1'b1; imask_wdata = 8'h20;
        expect_at(1, 3, 1, "R8");
        step(); imask_wr = 1'b0;

        repeat (4) step();
        if (q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule